// File: doc/BRIEF.md
# Four-Lane Immediate Swizzle Unit

This block reorders a four-lane vector held in a pair of 64-bit registers. It uses a 12-bit selector immediate to do this. Lane X is the low 32 bits of the first register and lane Y is its high 32 bits. Lanes Z and W are the low and high halves of the second register. Each destination lane has a 3-bit selector field. The field chooses one of four actions: copy any source lane into that destination lane, write constant zero, write constant one, or leave the lane alone. Leaving a lane alone works as a static predicate mask.

Two inputs decide how untouched lanes are handled. The first is a flag that says whether the source pair and the destination pair are the same registers. When they are the same, untouched lanes keep the current destination contents. When they are different, untouched lanes are cleared. The constant one is an integer 1 or single-precision 1.0, depending on a float-mode input. A selector code with no defined meaning raises an illegal-operation flag and suppresses every register write.

The unit has one register stage. A request presented with `in_vld` produces its result, write enables and illegal flag on the next cycle, marked by `out_vld`. The reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `swz_unit`

## Requirements
- R1: The selector field for destination lane k (X=0, Y=1, Z=2, W=3) is `sel_imm[3k+2:3k]`. Lanes X and Y are bits 31:0 and 63:32 of `res_r0`. Lanes Z and W are bits 31:0 and 63:32 of `res_r1`. Source lanes map the same way onto `src_r0`/`src_r1`.
- R2: A field value 1NN (binary, with NN from 0 to 3) places source lane NN in the destination lane.
- R3: Field value 010 places 32'h00000000 in the destination lane.
- R4: Field value 011 places 32'h00000001 when `fp_mode`=0 and 32'h3F800000 when `fp_mode`=1.
- R5: Field value 000 with `same_reg`=1 leaves the destination lane equal to the corresponding lane of `cur_r0`/`cur_r1`.
- R6: Field value 000 with `same_reg`=0 makes the destination lane zero.
- R7: With `same_reg`=1, `res_we[r]` is 1 exactly when at least one of register r's two lanes has a non-000 field. With `same_reg`=0, both bits of `res_we` are 1.
- R8: If any field equals 001, `res_illegal` is 1 and `res_we` is 2'b00. Otherwise `res_illegal` is 0.
- R9: Results appear one clock after the request. `out_vld` is high in the cycle after `in_vld` is high and low after a cycle without `in_vld`. Back-to-back requests are accepted on every cycle.
- R10: While reset is held, and until the first request completes, `out_vld`, `res_we` and `res_illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Request strobe |
| src_r0 | input | 64 | First source register (lanes X, Y) |
| src_r1 | input | 64 | Second source register (lanes Z, W) |
| cur_r0 | input | 64 | Current first destination register |
| cur_r1 | input | 64 | Current second destination register |
| sel_imm | input | 12 | Selector immediate, 3 bits per destination lane |
| fp_mode | input | 1 | 1 selects floating-point constant one |
| same_reg | input | 1 | Source pair equals destination pair |
| out_vld | output | 1 | Result strobe |
| res_r0 | output | 64 | New first destination register |
| res_r1 | output | 64 | New second destination register |
| res_we | output | 2 | Write enable per destination register |
| res_illegal | output | 1 | Reserved selector code seen |

## Verification
The assertions assume that `sel_imm`, `same_reg` and the `cur_*` inputs are stable and meaningful whenever `in_vld` is high. They sample these inputs only in that cycle and look one cycle ahead. The assertions also assume the register outputs are read only while `out_vld` is high. The data lanes are left unconstrained when the illegal flag is set. The stimulus changes inputs only on the falling edge and holds `in_vld` for a single cycle per request. Random selector fields are drawn from the seven defined codes, so illegal requests come only from directed vectors that place 001 in a chosen lane.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int LANE_W  = 32;
  localparam int LANES   = 4;
  localparam int REGS    = 2;
  localparam int IDX_W   = $clog2(LANES);
  localparam int SEL_W   = IDX_W + 1;
  localparam int IMM_W   = LANES * SEL_W;

  localparam logic [SEL_W-1:0] SEL_SKIP = 3'b000;
  localparam logic [SEL_W-1:0] SEL_RSVD = 3'b001;
  localparam logic [SEL_W-1:0] SEL_ZERO = 3'b010;
  localparam logic [SEL_W-1:0] SEL_ONE  = 3'b011;

  localparam logic [31:0] FP32_ONE = 32'h3F80_0000;
endpackage

// File: rtl/swz_lane_pick.sv
module swz_lane_pick
  import swz_pkg::*;
#(
  parameter int LANE_W = swz_pkg::LANE_W,
  parameter int LANES  = swz_pkg::LANES,
  parameter logic [LANE_W-1:0] FP_ONE_PAT = LANE_W'(FP32_ONE)
) (
  input  logic [SEL_W-1:0]        sel,
  input  logic [LANES*LANE_W-1:0] src_flat,
  input  logic                    fp_mode,
  output logic [LANE_W-1:0]       pick_val,
  output logic                    pick_wr,
  output logic                    pick_rsvd
);
  localparam int LIDX_W = $clog2(LANES);

  logic [LANE_W-1:0] src_lane [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_unpack
    assign src_lane[l] = src_flat[l*LANE_W +: LANE_W];
  end

  always_comb begin
    pick_val  = '0;
    pick_wr   = 1'b0;
    pick_rsvd = 1'b0;
    if (sel[SEL_W-1]) begin
      pick_val = src_lane[sel[LIDX_W-1:0]];
      pick_wr  = 1'b1;
    end else begin
      case (sel)
        SEL_ZERO: begin
          pick_val = '0;
          pick_wr  = 1'b1;
        end
        SEL_ONE: begin
          pick_val = fp_mode ? FP_ONE_PAT : LANE_W'(1);
          pick_wr  = 1'b1;
        end
        SEL_RSVD: pick_rsvd = 1'b1;
        default:  pick_wr   = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/swz_lane_merge.sv
module swz_lane_merge #(
  parameter int LANE_W = swz_pkg::LANE_W
) (
  input  logic [LANE_W-1:0] pick_val,
  input  logic              pick_wr,
  input  logic [LANE_W-1:0] cur_val,
  input  logic              same_reg,
  output logic [LANE_W-1:0] new_val
);
  always_comb begin
    if (pick_wr)       new_val = pick_val;
    else if (same_reg) new_val = cur_val;
    else               new_val = '0;
  end
endmodule

// File: rtl/swz_unit.sv
module swz_unit
  import swz_pkg::*;
#(
  parameter int LANE_W = swz_pkg::LANE_W,
  parameter logic [LANE_W-1:0] FP_ONE_PAT = LANE_W'(FP32_ONE)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [2*LANE_W-1:0]  src_r0,
  input  logic [2*LANE_W-1:0]  src_r1,
  input  logic [2*LANE_W-1:0]  cur_r0,
  input  logic [2*LANE_W-1:0]  cur_r1,
  input  logic [IMM_W-1:0]     sel_imm,
  input  logic                 fp_mode,
  input  logic                 same_reg,
  output logic                 out_vld,
  output logic [2*LANE_W-1:0]  res_r0,
  output logic [2*LANE_W-1:0]  res_r1,
  output logic [REGS-1:0]      res_we,
  output logic                 res_illegal
);
  localparam int REG_W  = 2 * LANE_W;
  localparam int FLAT_W = LANES * LANE_W;
  localparam int LPR    = LANES / REGS;

  // reset synchroniser: assert asynchronously, release on clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [FLAT_W-1:0] src_flat, cur_flat, new_flat;
  logic [LANES-1:0]  lane_wr, lane_rsvd;

  assign src_flat = {src_r1, src_r0};
  assign cur_flat = {cur_r1, cur_r0};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] pv;
    swz_lane_pick #(
      .LANE_W(LANE_W), .LANES(LANES), .FP_ONE_PAT(FP_ONE_PAT)
    ) i_pick (
      .sel      (sel_imm[l*SEL_W +: SEL_W]),
      .src_flat (src_flat),
      .fp_mode  (fp_mode),
      .pick_val (pv),
      .pick_wr  (lane_wr[l]),
      .pick_rsvd(lane_rsvd[l])
    );
    swz_lane_merge #(.LANE_W(LANE_W)) i_merge (
      .pick_val(pv),
      .pick_wr (lane_wr[l]),
      .cur_val (cur_flat[l*LANE_W +: LANE_W]),
      .same_reg(same_reg),
      .new_val (new_flat[l*LANE_W +: LANE_W])
    );
  end

  // next-state
  logic            any_rsvd;
  logic [REGS-1:0] nxt_we;
  logic [REG_W-1:0] nxt_r0, nxt_r1;

  assign any_rsvd = |lane_rsvd;
  assign nxt_r0   = new_flat[0 +: REG_W];
  assign nxt_r1   = new_flat[REG_W +: REG_W];

  for (genvar r = 0; r < REGS; r++) begin : g_we
    always_comb begin
      if (any_rsvd)      nxt_we[r] = 1'b0;
      else if (same_reg) nxt_we[r] = |lane_wr[r*LPR +: LPR];
      else               nxt_we[r] = 1'b1;
    end
  end

  // result register
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_vld     <= 1'b0;
      res_r0      <= '0;
      res_r1      <= '0;
      res_we      <= '0;
      res_illegal <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        res_r0      <= nxt_r0;
        res_r1      <= nxt_r1;
        res_we      <= nxt_we;
        res_illegal <= any_rsvd;
      end
    end
  end

  // R9
  out_vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_vld |=> out_vld);
  // R9
  out_vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_vld |=> !out_vld);
  // R8
  rsvd_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_vld && any_rsvd) |=> (res_illegal && res_we == '0));
  // R7
  split_writes_both_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_vld && !same_reg && !any_rsvd) |=> (res_we == '1 && !res_illegal));
  // R5
  skip_keeps_x_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_vld && same_reg && sel_imm[SEL_W-1:0] == SEL_SKIP)
      |=> res_r0[LANE_W-1:0] == $past(cur_r0[LANE_W-1:0]));
  // R6
  skip_clears_w_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_vld && !same_reg && sel_imm[IMM_W-1 -: SEL_W] == SEL_SKIP)
      |=> res_r1[REG_W-1 -: LANE_W] == '0);
endmodule

// File: tb/test_swz_unit.sv
`timescale 1ns/1ps
module test_swz_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [63:0] src_r0, src_r1, cur_r0, cur_r1;
  logic [11:0] sel_imm;
  logic        fp_mode, same_reg;
  logic        out_vld;
  logic [63:0] res_r0, res_r1;
  logic [1:0]  res_we;
  logic        res_illegal;

  always #4 clk = ~clk;

  swz_unit i_swz_unit (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .src_r0(src_r0), .src_r1(src_r1), .cur_r0(cur_r0), .cur_r1(cur_r1),
    .sel_imm(sel_imm), .fp_mode(fp_mode), .same_reg(same_reg),
    .out_vld(out_vld), .res_r0(res_r0), .res_r1(res_r1),
    .res_we(res_we), .res_illegal(res_illegal)
  );

  typedef struct {
    logic [63:0] r0, r1;
    logic [1:0]  we;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [63:0] s0, s1, c0, c1,
                                 input logic [11:0] imm, input logic fp,
                                 input logic same, input string tag);
    exp_t e;
    logic [31:0] s [4];
    logic [31:0] c [4];
    logic [31:0] o [4];
    logic [3:0]  hit;
    s[0] = s0[31:0]; s[1] = s0[63:32]; s[2] = s1[31:0]; s[3] = s1[63:32];
    c[0] = c0[31:0]; c[1] = c0[63:32]; c[2] = c1[31:0]; c[3] = c1[63:32];
    e.ill = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic [2:0] f;
      f = imm[3*k +: 3];
      hit[k] = 1'b1;
      if (f[2])           o[k] = s[f[1:0]];
      else if (f == 3'd2) o[k] = 32'h0;
      else if (f == 3'd3) o[k] = fp ? 32'h3F80_0000 : 32'h1;
      else begin
        hit[k] = 1'b0;
        o[k]   = same ? c[k] : 32'h0;
        if (f == 3'd1) e.ill = 1'b1;
      end
    end
    e.r0  = {o[1], o[0]};
    e.r1  = {o[3], o[2]};
    e.we  = e.ill ? 2'b00 : (same ? {hit[3] | hit[2], hit[1] | hit[0]} : 2'b11);
    e.tag = tag;
    return e;
  endfunction

  task automatic apply(input logic [63:0] s0, s1, c0, c1, input logic [11:0] imm,
                       input logic fp, input logic same, input string tag);
    @(negedge clk);
    src_r0 = s0; src_r1 = s1; cur_r0 = c0; cur_r1 = c1;
    sel_imm = imm; fp_mode = fp; same_reg = same; in_vld = 1'b1;
    sb.push_back(model(s0, s1, c0, c1, imm, fp, same, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done && out_vld) begin
      if (sb.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R9: actual out_vld=1 expected 0 (no pending request)");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " illegal"}, 64'(res_illegal), 64'(e.ill));
        check({e.tag, " we"}, 64'(res_we), 64'(e.we));
        if (!e.ill) begin
          check({e.tag, " r0"}, res_r0, e.r0);
          check({e.tag, " r1"}, res_r1, e.r1);
        end
      end
    end
  end

  function automatic logic [2:0] legal_code();
    int p;
    p = $urandom % 7;
    return (p == 0) ? 3'd0 : 3'(p + 1);
  endfunction

  localparam logic [63:0] S0 = 64'hBBBB_0001_AAAA_0000;
  localparam logic [63:0] S1 = 64'hDDDD_0003_CCCC_0002;
  localparam logic [63:0] C0 = 64'h5555_1111_4444_0000;
  localparam logic [63:0] C1 = 64'h7777_3333_6666_2222;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0;
    src_r0 = '0; src_r1 = '0; cur_r0 = '0; cur_r1 = '0;
    sel_imm = '0; fp_mode = 1'b0; same_reg = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 out_vld", 64'(out_vld), 64'd0);
    check("R10 we", 64'(res_we), 64'd0);
    check("R10 illegal", 64'(res_illegal), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 out_vld after release", 64'(out_vld), 64'd0);

    // R1 identity and single-field placement
    apply(S0, S1, C0, C1, 12'hFAC, 1'b0, 1'b0, "R1 identity");
    apply(S0, S1, C0, C1, 12'(3'b111 << 6), 1'b0, 1'b1, "R1 Z field only");
    apply(S0, S1, C0, C1, 12'(3'b100 << 9), 1'b0, 1'b0, "R1 W field only");
    // R2 reverse and broadcast
    apply(S0, S1, C0, C1, {3'b100, 3'b101, 3'b110, 3'b111}, 1'b0, 1'b0, "R2 reverse");
    apply(S0, S1, C0, C1, {4{3'b110}}, 1'b0, 1'b1, "R2 broadcast Z");
    // R3 / R4 constants
    apply(S0, S1, C0, C1, {4{3'b010}}, 1'b0, 1'b1, "R3 all zero");
    apply(S0, S1, C0, C1, {3'b011, 3'b010, 3'b011, 3'b010}, 1'b0, 1'b0, "R4 int one");
    apply(S0, S1, C0, C1, {4{3'b011}}, 1'b1, 1'b1, "R4 fp one");
    // R5 / R6 skip semantics, "..XY" style
    apply(S0, S1, C0, C1, {3'b101, 3'b100, 3'b000, 3'b000}, 1'b0, 1'b1, "R5 in-place skip");
    apply(S0, S1, C0, C1, {3'b000, 3'b000, 3'b101, 3'b100}, 1'b0, 1'b0, "R6 split skip");
    apply(S0, S1, C0, C1, 12'h000, 1'b0, 1'b0, "R6 all skip split");
    // R7 write enables
    apply(S0, S1, C0, C1, 12'h000, 1'b0, 1'b1, "R7 all skip in-place");
    apply(S0, S1, C0, C1, {3'b000, 3'b111, 3'b000, 3'b000}, 1'b0, 1'b1, "R7 Z only in-place");
    apply(S0, S1, C0, C1, {3'b000, 3'b000, 3'b110, 3'b000}, 1'b0, 1'b1, "R7 Y only in-place");
    idle();
    idle();
    // R9 idle output
    check("R9 idle out_vld", 64'(out_vld), 64'd0);
    // R8 reserved code in each lane
    for (int k = 0; k < 4; k++) begin
      logic [11:0] imm;
      imm = 12'hFAC;
      imm[3*k +: 3] = 3'b001;
      apply(S0, S1, C0, C1, imm, 1'b0, k[0], "R8 reserved");
    end
    idle();
    // R2 random legal vectors, back to back
    for (int n = 0; n < 300; n++) begin
      logic [11:0] imm;
      for (int k = 0; k < 4; k++) imm[3*k +: 3] = legal_code();
      apply({$urandom, $urandom}, {$urandom, $urandom},
            {$urandom, $urandom}, {$urandom, $urandom},
            imm, 1'($urandom), 1'($urandom), "R2 random");
      if (n % 37 == 0) idle();
    end
    idle();
    idle();
    // R9 every request returned
    check("R9 pending", 64'(sb.size()), 64'd0);
    finish_run();
  end
endmodule